// File: doc/BRIEF.md
# PHY Management Register Controller with Emulated Transceiver Registers

This block gives software a small register window for managing an Ethernet transceiver over its management channel. Four 32-bit host registers sit behind a simple write-strobe bus: a control word, a command word, an outgoing data word and an incoming data word. When software writes a command with its start flag raised, the controller does a single PHY register access at once, either storing the outgoing data word into the chosen PHY register or capturing that register into the incoming data word. No serial bit timing is modelled, so every access finishes in the same clock edge.

One emulated transceiver sits at a parameterised 5-bit management address. Most of its 32 registers are plain 16-bit storage, preloaded with identification and advertisement values at reset. A few registers are computed on the fly: the basic status register and a vendor diagnostic register follow an external link flag, the partner-ability register echoes the local advertisement, and a speed register reports a fixed gigabit indication. Any write to the transceiver clears the soft-reset bit of its control register.

Top module: `mdio_mgmt_model`

## Requirements
- R1: After reset the host control, outgoing and incoming data words read 0, the command word reads 0x00000080, and PHY registers 0, 2, 3 and 4 hold 0x3100, 0x0300, 0xE400 and 0x01E1 (all other stored PHY registers 0).
- R2: The command word carries the PHY address in bits 28:24, the PHY register number in bits 20:16, the opcode in bits 15:14 and the start flag in bit 11; a command written with bit 11 clear performs no PHY access.
- R3: A started command with opcode 1 stores bits 15:0 of the outgoing data word into the addressed PHY register, and a later read of a stored (non-computed) register returns it.
- R4: A started command with opcode 2 loads the incoming data word with the addressed PHY register value, zero-extended to 32 bits, visible from the next clock edge.
- R5: A started command with opcode 0 or 3 changes neither the PHY registers nor the incoming data word.
- R6: The command word reads back as last written, with bit 7 always forced to 1 (always ready).
- R7: A read at any PHY address other than the configured one returns 0x0000FFFF; a write there changes nothing.
- R8: PHY register 1 reads 0x782E while the link flag is high and 0x0000 while it is low.
- R9: PHY register 5 reads 0x4001 ORed with bits 8:5 of PHY register 4.
- R10: PHY register 17 always reads 0x8000.
- R11: PHY register 18 reads 0 with the link low; with the link high bit 10 is set when register 4 bit 7 or bit 8 is set, and bit 11 is set when register 4 bit 8 or bit 6 is set, all other bits 0.
- R12: Every PHY write leaves bit 15 of PHY register 0 clear, including a write of that bit itself.
- R13: Only bits 6:0 of the control word are kept (bit 6 enable, bits 5:0 clock divide); bits 31:7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link state reported by the emulated transceiver |
| host_wr | input | 1 | Host write strobe |
| host_wsel | input | 2 | Write target: 0 control, 1 command, 2 outgoing data, 3 incoming data |
| host_wdata | input | BUS_W | Host write data |
| host_rsel | input | 2 | Read select, same encoding as host_wsel |
| host_rdata | output | BUS_W | Read data for host_rsel (combinational) |

## Verification
A corrupted PHY register, a wrong field slice of the command word or a broken address compare shows up on host_rdata one edge after the read command that targets it, since the incoming data word is loaded on that edge. Errors in the computed registers appear only through reads of registers 1, 5, 17 and 18, so the bench sweeps every register number, every management address and every combination of the four advertisement bits under both link states. A missed soft-reset clear is visible on the first register 0 read after any write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   // Host register selects
   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_CMD   = 2'd1,
      SEL_WDATA = 2'd2,
      SEL_RDATA = 2'd3
   } host_sel_e;

   // Command word field positions
   localparam int CMD_PHY_LSB = 24;
   localparam int CMD_REG_LSB = 16;
   localparam int CMD_OP_LSB  = 14;
   localparam int CMD_GO_BIT  = 11;
   localparam int FIELD_W     = 5;
   localparam int READY_BIT   = 7;
   localparam int CTRL_W      = 7;

   localparam logic [1:0] OP_WRITE = 2'd1;
   localparam logic [1:0] OP_READ  = 2'd2;

   // Emulated transceiver
   localparam int PHY_W = 16;
   localparam int IDX_STATUS  = 1;
   localparam int IDX_ADV     = 4;
   localparam int IDX_PARTNER = 5;
   localparam int IDX_SPEED   = 17;
   localparam int IDX_DIAG    = 18;

   localparam logic [PHY_W-1:0] STATUS_LINKED = 16'h782E;
   localparam logic [PHY_W-1:0] PARTNER_BASE  = 16'h4001;
   localparam logic [PHY_W-1:0] ADV_MODES     = 16'h01E0;
   localparam logic [PHY_W-1:0] SPEED_GIG     = 16'h8000;
   localparam logic [PHY_W-1:0] NO_DEVICE     = 16'hFFFF;

   typedef struct packed {
      logic               go;
      logic [1:0]         op;
      logic [FIELD_W-1:0] phy;
      logic [FIELD_W-1:0] regnum;
   } mgmt_req_t;

   function automatic logic [PHY_W-1:0] phy_reset_value(input int idx);
      case (idx)
         0:       return 16'h3100;
         2:       return 16'h0300;
         3:       return 16'hE400;
         4:       return 16'h01E1;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [BUS_W-1:0] wr_data,
   output logic             ctrl_wr,
   output logic             cmd_wr,
   output logic             wdata_wr,
   output logic             rdata_wr,
   output mgmt_req_t        req,
   output logic             do_write,
   output logic             do_read
);

   initial begin
      assert (BUS_W >= CMD_PHY_LSB + FIELD_W)
         else $error("BUS_W too narrow for command fields");
   end

   wire unused_ok = &{1'b0, wr_data};

   always_comb begin
      ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
      cmd_wr   = wr_en && (wr_sel == SEL_CMD);
      wdata_wr = wr_en && (wr_sel == SEL_WDATA);
      rdata_wr = wr_en && (wr_sel == SEL_RDATA);

      req.go     = wr_data[CMD_GO_BIT];
      req.op     = wr_data[CMD_OP_LSB +: 2];
      req.phy    = wr_data[CMD_PHY_LSB +: FIELD_W];
      req.regnum = wr_data[CMD_REG_LSB +: FIELD_W];

      do_write = cmd_wr && req.go && (req.op == OP_WRITE);
      do_read  = cmd_wr && req.go && (req.op == OP_READ);
   end

endmodule

// File: rtl/mdio_phy_regfile.sv
module mdio_phy_regfile
   import mdio_mgmt_pkg::*;
#(
   parameter  int REG_W = 16,
   parameter  int NREGS = 32,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_up,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [REG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [REG_W-1:0] rd_data,
   output logic             ctl_msb
);

   initial begin
      assert (REG_W == PHY_W) else $error("REG_W must equal PHY_W");
      assert (NREGS > IDX_DIAG) else $error("NREGS too small");
      assert ((1 << IDX_W) == NREGS) else $error("NREGS must be a power of two");
   end

   logic [REG_W-1:0] store_q [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      localparam logic [REG_W-1:0] RV = phy_reset_value(g);
      logic [REG_W-1:0] q;
      logic             hit;
      assign hit = wr_en && (wr_idx == IDX_W'(g));

      if (g == 0) begin : g_ctl
         // soft-reset bit self-clears on any write
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= RV;
            else if (hit)    q <= {1'b0, wr_data[REG_W-2:0]};
            else if (wr_en)  q[REG_W-1] <= 1'b0;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= RV;
            else if (hit) q <= wr_data;
         end
      end
      assign store_q[g] = q;
   end

   logic [REG_W-1:0] adv;
   logic             adv_100, adv_full;

   always_comb begin
      adv      = store_q[IDX_ADV];
      adv_100  = adv[7] | adv[8];
      adv_full = adv[8] | adv[6];
      case (rd_idx)
         IDX_W'(IDX_STATUS):  rd_data = link_up ? STATUS_LINKED : '0;
         IDX_W'(IDX_PARTNER): rd_data = PARTNER_BASE | (adv & ADV_MODES);
         IDX_W'(IDX_SPEED):   rd_data = SPEED_GIG;
         IDX_W'(IDX_DIAG):    rd_data = link_up ? {4'b0, adv_full, adv_100, 10'b0} : '0;
         default:             rd_data = store_q[rd_idx];
      endcase
   end

   assign ctl_msb = store_q[0][REG_W-1];

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic             cmd_wr,
   input  logic             wdata_wr,
   input  logic             rdata_wr,
   input  logic             rd_load,
   input  logic [BUS_W-1:0] wr_data,
   input  logic [BUS_W-1:0] rd_value,
   input  logic [1:0]       rd_sel,
   output logic [BUS_W-1:0] rd_data,
   output logic [BUS_W-1:0] wdata_q,
   output logic [BUS_W-1:0] rdata_q
);

   initial begin
      assert (BUS_W > READY_BIT) else $error("BUS_W too narrow");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [BUS_W-1:0]  cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cmd_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (ctrl_wr)  ctrl_q  <= wr_data[CTRL_W-1:0];
         if (cmd_wr)   cmd_q   <= wr_data;
         if (wdata_wr) wdata_q <= wr_data;
         if (rd_load)       rdata_q <= rd_value;
         else if (rdata_wr) rdata_q <= wr_data;
      end
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL:  rd_data = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
         SEL_CMD: begin
            rd_data = cmd_q;
            rd_data[READY_BIT] = 1'b1;
         end
         SEL_WDATA: rd_data = wdata_q;
         default:   rd_data = rdata_q;
      endcase
   end

endmodule

// File: rtl/mdio_mgmt_model.sv
module mdio_mgmt_model
   import mdio_mgmt_pkg::*;
#(
   parameter int BUS_W       = 32,
   parameter int PHY_ADDR    = 7,
   parameter bit PHY_PRESENT = 1'b1,
   parameter int NREGS       = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             link_up,
   input  logic             host_wr,
   input  logic [1:0]       host_wsel,
   input  logic [BUS_W-1:0] host_wdata,
   input  logic [1:0]       host_rsel,
   output logic [BUS_W-1:0] host_rdata
);

   initial begin
      assert (PHY_ADDR >= 0 && PHY_ADDR < (1 << FIELD_W))
         else $error("PHY_ADDR out of range");
      assert (NREGS == (1 << FIELD_W)) else $error("NREGS must match register field");
   end

   logic             ctrl_wr, cmd_wr, wdata_wr, rdata_wr;
   logic             do_write, do_read;
   mgmt_req_t        req;
   logic             addr_hit;
   logic             phy_wr_en;
   logic             ctl_msb;
   logic [BUS_W-1:0] rd_value;
   logic [BUS_W-1:0] wdata_q;
   logic [BUS_W-1:0] rdata_q;

   mdio_cmd_decode #(.BUS_W(BUS_W)) u_dec (
      .wr_en    (host_wr),
      .wr_sel   (host_wsel),
      .wr_data  (host_wdata),
      .ctrl_wr  (ctrl_wr),
      .cmd_wr   (cmd_wr),
      .wdata_wr (wdata_wr),
      .rdata_wr (rdata_wr),
      .req      (req),
      .do_write (do_write),
      .do_read  (do_read)
   );

   assign addr_hit = (req.phy == FIELD_W'(PHY_ADDR));

   if (PHY_PRESENT) begin : g_phy
      logic [PHY_W-1:0] phy_rd;
      assign phy_wr_en = do_write && addr_hit;

      mdio_phy_regfile #(.REG_W(PHY_W), .NREGS(NREGS)) u_phy (
         .clk     (clk),
         .rst_n   (rst_n),
         .link_up (link_up),
         .wr_en   (phy_wr_en),
         .wr_idx  (req.regnum),
         .wr_data (wdata_q[PHY_W-1:0]),
         .rd_idx  (req.regnum),
         .rd_data (phy_rd),
         .ctl_msb (ctl_msb)
      );

      assign rd_value = addr_hit ? {{(BUS_W-PHY_W){1'b0}}, phy_rd}
                                 : {{(BUS_W-PHY_W){1'b0}}, NO_DEVICE};
   end else begin : g_nophy
      wire unused_nophy = &{1'b0, link_up, addr_hit, do_write};
      assign phy_wr_en = 1'b0;
      assign ctl_msb   = 1'b0;
      assign rd_value  = {{(BUS_W-PHY_W){1'b0}}, NO_DEVICE};
   end

   mdio_host_regs #(.BUS_W(BUS_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_wr  (ctrl_wr),
      .cmd_wr   (cmd_wr),
      .wdata_wr (wdata_wr),
      .rdata_wr (rdata_wr),
      .rd_load  (do_read),
      .wr_data  (host_wdata),
      .rd_value (rd_value),
      .rd_sel   (host_rsel),
      .rd_data  (host_rdata),
      .wdata_q  (wdata_q),
      .rdata_q  (rdata_q)
   );

endmodule

// File: rtl/mdio_mgmt_model_chk.sv
module mdio_mgmt_model_chk #(
   parameter int BUS_W    = 32,
   parameter int PHY_ADDR = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic [1:0]       host_wsel,
   input logic [BUS_W-1:0] host_wdata,
   input logic [1:0]       host_rsel,
   input logic [BUS_W-1:0] host_rdata,
   input logic [BUS_W-1:0] rdata_q,
   input logic             phy_wr_en,
   input logic             ctl_msb
);

   logic cmd_go, cmd_nogo, cmd_rd, cmd_bad;
   assign cmd_go   = host_wr && host_wsel == 2'd1 && host_wdata[11];
   assign cmd_nogo = host_wr && host_wsel == 2'd1 && !host_wdata[11];
   assign cmd_rd   = cmd_go && host_wdata[15:14] == 2'd2;
   assign cmd_bad  = cmd_go && (host_wdata[15:14] == 2'd0 || host_wdata[15:14] == 2'd3);

   assert_ready_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rsel == 2'd1 |-> host_rdata[7]);

   assert_ctrl_width_R13: assert property (@(posedge clk) disable iff (!rst_n)
      host_rsel == 2'd0 |-> host_rdata[BUS_W-1:7] == '0);

   assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_nogo |=> $stable(rdata_q));

   assert_no_start_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_nogo |-> !phy_wr_en);

   assert_bad_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_bad |=> $stable(rdata_q));

   assert_bad_op_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_bad |-> !phy_wr_en);

   assert_absent_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && host_wdata[28:24] != 5'(PHY_ADDR)) |=> rdata_q == BUS_W'(32'h0000FFFF));

   assert_read_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rd |=> rdata_q[BUS_W-1:16] == '0);

   assert_write_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_wr_en |-> host_wdata[28:24] == 5'(PHY_ADDR));

   assert_soft_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      phy_wr_en |=> !ctl_msb);

endmodule

bind mdio_mgmt_model mdio_mgmt_model_chk #(.BUS_W(BUS_W), .PHY_ADDR(PHY_ADDR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_wsel  (host_wsel),
   .host_wdata (host_wdata),
   .host_rsel  (host_rsel),
   .host_rdata (host_rdata),
   .rdata_q    (rdata_q),
   .phy_wr_en  (phy_wr_en),
   .ctl_msb    (ctl_msb)
);

// File: tb/mdio_mgmt_model_test.sv
module mdio_mgmt_model_test;

   localparam int CLK_PERIOD = 10;
   localparam int PHY_AT     = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b1;
   logic        host_wr = 1'b0;
   logic [1:0]  host_wsel = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [1:0]  host_rsel = 2'd0;
   logic [31:0] host_rdata;

   int checks = 0;
   int errors = 0;
   logic finished = 1'b0;

   logic [15:0] mdl [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_mgmt_model #(.PHY_ADDR(PHY_AT)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_up    (link_up),
      .host_wr    (host_wr),
      .host_wsel  (host_wsel),
      .host_wdata (host_wdata),
      .host_rsel  (host_rsel),
      .host_rdata (host_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      host_wr = 1'b1; host_wsel = sel; host_wdata = data;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [1:0] sel, output logic [31:0] data);
      host_rsel = sel;
      #1;
      data = host_rdata;
   endtask

   function automatic logic [31:0] mk_cmd(input int phy, input int rg, input int op, input bit go);
      return (32'(phy) << 24) | (32'(rg) << 16) | (32'(op) << 14) | (32'(go) << 11);
   endfunction

   task automatic phy_read(input int phy, input int rg, output logic [31:0] data);
      host_write(2'd1, mk_cmd(phy, rg, 2, 1'b1));
      host_read(2'd3, data);
   endtask

   task automatic phy_write(input int phy, input int rg, input logic [15:0] v);
      host_write(2'd2, {16'h0, v});
      host_write(2'd1, mk_cmd(phy, rg, 1, 1'b1));
      if (phy == PHY_AT) begin
         mdl[rg] = v;
         mdl[0][15] = 1'b0;
      end
   endtask

   function automatic logic [31:0] exp_read(input int rg);
      logic h, f;
      h = mdl[4][7] | mdl[4][8];
      f = mdl[4][8] | mdl[4][6];
      case (rg)
         1:  return link_up ? 32'h782E : 32'h0;
         5:  return 32'h4001 | {16'h0, mdl[4] & 16'h01E0};
         17: return 32'h8000;
         18: return link_up ? ((32'(h) << 10) | (32'(f) << 11)) : 32'h0;
         default: return {16'h0, mdl[rg]};
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 32; i++) mdl[i] = 16'h0;
      mdl[0] = 16'h3100; mdl[2] = 16'h0300; mdl[3] = 16'hE400; mdl[4] = 16'h01E1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: host registers after reset
      host_read(2'd0, v); check("R1 ctrl", v, 32'h0);
      host_read(2'd1, v); check("R1 cmd", v, 32'h80);
      host_read(2'd2, v); check("R1 wdata", v, 32'h0);
      host_read(2'd3, v); check("R1 rdata", v, 32'h0);

      // R13: control keeps 7 bits
      host_write(2'd0, 32'hFFFF_FFFF);
      host_read(2'd0, v); check("R13 all ones", v, 32'h7F);
      host_write(2'd0, 32'h1234_5645);
      host_read(2'd0, v); check("R13 pattern", v, 32'h45);

      // R6 / R2: command readback, no start
      host_write(2'd1, 32'h00AB_0000);
      host_read(2'd1, v); check("R6 ready bit", v, 32'h00AB_0080);
      host_read(2'd3, v); check("R2 no start leaves rdata", v, 32'h0);

      // R1 R8 R9 R10 R11: every register at reset contents
      for (int r = 0; r < 32; r++) begin
         phy_read(PHY_AT, r, v);
         check($sformatf("R1 default reg %0d", r), v, exp_read(r));
      end

      // R7 / R2: address sweep
      for (int a = 0; a < 32; a++) begin
         phy_read(a, 2, v);
         check($sformatf("R7 addr %0d", a), v, (a == PHY_AT) ? 32'h0300 : 32'h0000FFFF);
      end

      // R3 R12: write every register, read all back
      for (int r = 0; r < 32; r++)
         phy_write(PHY_AT, r, 16'h5A00 ^ 16'(r * 16'h0111));
      for (int r = 0; r < 32; r++) begin
         phy_read(PHY_AT, r, v);
         check($sformatf("R3 readback reg %0d", r), v, exp_read(r));
      end

      // R9 R11 R8: advertisement sweep under both link states
      for (int k = 0; k < 16; k++) begin
         phy_write(PHY_AT, 4, 16'(k << 5) | 16'h0001);
         link_up = 1'b1;
         phy_read(PHY_AT, 5, v);  check($sformatf("R9 adv %0d", k), v, exp_read(5));
         phy_read(PHY_AT, 18, v); check($sformatf("R11 up adv %0d", k), v, exp_read(18));
         phy_read(PHY_AT, 1, v);  check("R8 link up", v, 32'h782E);
         phy_read(PHY_AT, 17, v); check("R10 speed", v, 32'h8000);
         @(negedge clk); link_up = 1'b0;
         phy_read(PHY_AT, 18, v); check($sformatf("R11 down adv %0d", k), v, 32'h0);
         phy_read(PHY_AT, 1, v);  check("R8 link down", v, 32'h0);
         phy_read(PHY_AT, 17, v); check("R10 speed down", v, 32'h8000);
         @(negedge clk); link_up = 1'b1;
      end

      // R12: soft-reset bit
      phy_write(PHY_AT, 0, 16'h8123);
      phy_read(PHY_AT, 0, v); check("R12 own write", v, 32'h0123);
      phy_write(PHY_AT, 9, 16'hBEEF);
      phy_read(PHY_AT, 0, v); check("R12 other write", v, 32'h0123);

      // R5: invalid opcodes
      phy_read(PHY_AT, 17, v);
      host_write(2'd2, 32'h0000_1111);
      host_write(2'd1, mk_cmd(PHY_AT, 9, 0, 1'b1));
      host_read(2'd3, v); check("R5 op0 rdata", v, 32'h8000);
      host_write(2'd1, mk_cmd(PHY_AT, 9, 3, 1'b1));
      host_read(2'd3, v); check("R5 op3 rdata", v, 32'h8000);
      phy_read(PHY_AT, 9, v); check("R5 reg unchanged", v, 32'hBEEF);

      // R2: write opcode without start flag
      host_write(2'd2, 32'h0000_2222);
      host_write(2'd1, mk_cmd(PHY_AT, 9, 1, 1'b0));
      phy_read(PHY_AT, 9, v); check("R2 no start write", v, 32'hBEEF);

      // R7: write at absent address
      phy_write(3, 9, 16'h3333);
      phy_read(PHY_AT, 9, v); check("R7 absent write", v, 32'hBEEF);

      // R4: upper bits of outgoing word not passed, read zero-extended
      host_write(2'd2, 32'hFFFF_4444);
      host_write(2'd1, mk_cmd(PHY_AT, 10, 1, 1'b1));
      mdl[10] = 16'h4444;
      phy_read(PHY_AT, 10, v); check("R4 zero extend", v, 32'h0000_4444);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule